// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block compares two IEEE-754 single-precision words, A and B, and reports the relation between them as a set of condition flags. A caller presents both operands together with a one-cycle `load` strobe. On the following clock edge the block registers greater-than, less-than, equal and unordered outcomes, together with three status bits: an infinity is present, A is zero, and a signalling NaN was seen (invalid operation). `ready` is high for the cycle in which the newly registered flags first appear. The flags then hold until the next load.

Each operand is first decoded into a class: NaN (exponent all ones, fraction nonzero), infinity (exponent all ones, fraction zero) or zero (exponent and fraction zero, either sign). Operands that are not NaN are ordered by sign and magnitude, so subnormals, normals and infinities fall into their numeric order, and the two signed zeros compare equal. If either operand is a NaN, the pair is unordered and the three relational flags stay low. A parameter selects between two equivalent ordering circuits.

Top module: `fpcmp_unit`

## Requirements
- R1: While reset is asserted, and after it until the first load, `gt`, `lt`, `eq`, `unordered`, `inf_any`, `a_zero`, `invalid` and `ready` are all 0.
- R2: When `load` is high at a rising clock edge, the flags for the operands present at that edge appear after that edge, and `ready` is high for that one cycle. While `load` stays low, `ready` is 0 and the flags keep their values even if the operands change. Back-to-back loads keep `ready` high and update the flags at every edge.
- R3: For two operands that are not NaN, `gt` is 1 exactly when A is numerically greater than B, including any positive value against any negative value.
- R4: For two operands that are not NaN, `lt` is 1 exactly when A is numerically less than B.
- R5: For two operands that are not NaN, `eq` is 1 exactly when they are numerically equal. +0 (0x00000000) and -0 (0x80000000) are equal.
- R6: When both operands are negative, the one with the larger magnitude is the smaller value.
- R7: An operand is a NaN when its exponent bits [30:23] are all ones and its fraction bits [22:0] are nonzero. If either operand is a NaN, `unordered` is 1 and `gt`, `lt` and `eq` are 0.
- R8: `inf_any` is 1 when either operand has all-ones exponent bits and a zero fraction (0x7F800000 or 0xFF800000), whatever the other operand is.
- R9: `a_zero` is 1 exactly when bits [30:0] of A are zero, whatever its sign bit. The value of B has no effect on it.
- R10: `invalid` is 1 when either operand is a signalling NaN, which is a NaN whose fraction bit 22 is 0. A quiet NaN (bit 22 set) does not raise it.
- R11: Subnormals order by magnitude. The smallest positive subnormal is above zero, the largest subnormal is below the smallest normal, and +infinity is above the largest finite value.
- R12: Whenever `ready` is 1, exactly one of `gt`, `lt`, `eq` and `unordered` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture strobe for the operands |
| op_a | input | 32 | Operand A, single-precision word |
| op_b | input | 32 | Operand B, single-precision word |
| gt | output | 1 | A is greater than B |
| lt | output | 1 | A is less than B |
| eq | output | 1 | A equals B |
| unordered | output | 1 | At least one operand is a NaN |
| inf_any | output | 1 | At least one operand is infinite |
| a_zero | output | 1 | A is zero of either sign |
| invalid | output | 1 | A signalling NaN was presented |
| ready | output | 1 | Flags were updated on the last edge |

## Verification
The bench targets the places where a comparator based on integer compare goes wrong. Two negative operands must come out in reverse magnitude order; a design that skips the reversal reports -2 above -1. The pair +0 and -0 must report equal; a raw bit compare reports one above the other. A NaN must mask all relational flags; a design that treats it as a very large number reports `gt` or `lt`. Signalling NaNs must be told apart from quiet ones by fraction bit 22, and `a_zero` must ignore both the sign of A and the value of B. The timing checks confirm that `ready` lasts one cycle per load and that flags do not move while `load` is low.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

   // Decoded class of one operand
   typedef struct packed {
      logic nan;
      logic snan;
      logic inf;
      logic zero;
   } fp_class_t;

   // Registered result bundle, most significant first
   typedef struct packed {
      logic gt;
      logic lt;
      logic eq;
      logic unord;
      logic inf_any;
      logic a_zero;
      logic invalid;
   } cmp_flags_t;

   // Choice of ordering circuit
   typedef enum logic [0:0] {
      ORD_KEY     = 1'b0,   // map to a monotonic unsigned key, one compare
      ORD_SIGNMAG = 1'b1    // explicit sign test plus magnitude compare
   } order_style_e;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
   import fpcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] word,
   output fp_class_t         cls
);

   initial begin
      assert (EXP_W >= 2) else $error("fpcmp_classify: EXP_W must be at least 2");
      assert (FRAC_W >= 2) else $error("fpcmp_classify: FRAC_W must be at least 2");
   end

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_max;
   logic              exp_min;
   logic              frac_nz;

   assign exp_f   = word[WORD_W-2 -: EXP_W];
   assign frac_f  = word[FRAC_W-1:0];
   assign exp_max = &exp_f;
   assign exp_min = ~|exp_f;
   assign frac_nz = |frac_f;

   always_comb begin
      cls.nan  = exp_max & frac_nz;
      cls.snan = exp_max & frac_nz & ~frac_f[FRAC_W-1];
      cls.inf  = exp_max & ~frac_nz;
      cls.zero = exp_min & ~frac_nz;
   end

   // A word belongs to at most one of NaN, infinity, zero
   always_comb begin
      assert ($countones({cls.nan, cls.inf, cls.zero}) <= 1)
         else $error("assert_class_exclusive_R7: overlapping operand classes");
   end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
   import fpcmp_pkg::*;
#(
   parameter int           EXP_W  = 8,
   parameter int           FRAC_W = 23,
   parameter order_style_e STYLE  = ORD_KEY,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int MAG_W  = WORD_W - 1
) (
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic              a_is_zero,
   input  logic              b_is_zero,
   output logic              a_gt,
   output logic              a_lt,
   output logic              a_eq
);

   logic             sa;
   logic             sb;
   logic [MAG_W-1:0] ma;
   logic [MAG_W-1:0] mb;

   assign sa = a[WORD_W-1];
   assign sb = b[WORD_W-1];
   assign ma = a[MAG_W-1:0];
   assign mb = b[MAG_W-1:0];

   generate
      if (STYLE == ORD_KEY) begin : g_key
         // Monotonic key: positive values above negatives, negative
         // magnitudes inverted; both zeros collapse onto the +0 key.
         logic [WORD_W-1:0] ka;
         logic [WORD_W-1:0] kb;

         always_comb begin
            if (a_is_zero)  ka = {1'b1, {MAG_W{1'b0}}};
            else if (sa)    ka = {1'b0, ~ma};
            else            ka = {1'b1, ma};
            if (b_is_zero)  kb = {1'b1, {MAG_W{1'b0}}};
            else if (sb)    kb = {1'b0, ~mb};
            else            kb = {1'b1, mb};
         end

         assign a_gt = ka > kb;
         assign a_lt = ka < kb;
         assign a_eq = ka == kb;
      end else begin : g_signmag
         logic mag_gt;
         logic mag_lt;

         assign mag_gt = ma > mb;
         assign mag_lt = ma < mb;

         always_comb begin
            a_gt = 1'b0;
            a_lt = 1'b0;
            a_eq = 1'b0;
            if (a_is_zero && b_is_zero) begin
               a_eq = 1'b1;
            end else if (sa != sb) begin
               a_gt = sb;
               a_lt = sa;
            end else if (!mag_gt && !mag_lt) begin
               a_eq = 1'b1;
            end else begin
               // Same sign: negative operands reverse the magnitude order
               a_gt = sa ? mag_lt : mag_gt;
               a_lt = sa ? mag_gt : mag_lt;
            end
         end
      end
   endgenerate

   always_comb begin
      assert ($countones({a_gt, a_lt, a_eq}) == 1)
         else $error("assert_order_onehot_R3: ordering outcome not one-hot");
   end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
   import fpcmp_pkg::*;
#(
   parameter int           EXP_W  = 8,
   parameter int           FRAC_W = 23,
   parameter order_style_e STYLE  = ORD_KEY,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   output logic              gt,
   output logic              lt,
   output logic              eq,
   output logic              unordered,
   output logic              inf_any,
   output logic              a_zero,
   output logic              invalid,
   output logic              ready
);

   fp_class_t  cls_a;
   fp_class_t  cls_b;
   logic       raw_gt;
   logic       raw_lt;
   logic       raw_eq;
   cmp_flags_t next_flags;
   cmp_flags_t flags_q;
   logic       ready_q;

   fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
      .word (op_a),
      .cls  (cls_a)
   );

   fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
      .word (op_b),
      .cls  (cls_b)
   );

   fpcmp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .STYLE(STYLE)) u_order (
      .a         (op_a),
      .b         (op_b),
      .a_is_zero (cls_a.zero),
      .b_is_zero (cls_b.zero),
      .a_gt      (raw_gt),
      .a_lt      (raw_lt),
      .a_eq      (raw_eq)
   );

   // NaN masks the relational result
   always_comb begin
      next_flags.unord   = cls_a.nan | cls_b.nan;
      next_flags.gt      = raw_gt & ~next_flags.unord;
      next_flags.lt      = raw_lt & ~next_flags.unord;
      next_flags.eq      = raw_eq & ~next_flags.unord;
      next_flags.inf_any = cls_a.inf | cls_b.inf;
      next_flags.a_zero  = cls_a.zero;
      next_flags.invalid = cls_a.snan | cls_b.snan;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= load;
         if (load) flags_q <= next_flags;
      end
   end

   assign gt        = flags_q.gt;
   assign lt        = flags_q.lt;
   assign eq        = flags_q.eq;
   assign unordered = flags_q.unord;
   assign inf_any   = flags_q.inf_any;
   assign a_zero    = flags_q.a_zero;
   assign invalid   = flags_q.invalid;
   assign ready     = ready_q;

   assert_ready_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ready);

   assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> !ready);

   assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable({gt, lt, eq, unordered, inf_any, a_zero, invalid}));

   assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> ($countones({gt, lt, eq, unordered}) == 1));

   assert_snan_unordered_R10: assert property (@(posedge clk) disable iff (!rst_n)
      invalid |-> unordered);

   assert_zero_signless_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (op_a[WORD_W-2:0] == '0)) |=> a_zero);

   assert_inf_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (&op_a[WORD_W-2 -: EXP_W]) && (op_a[FRAC_W-1:0] == '0)) |=> inf_any);

endmodule

// File: tb/fpcmp_unit_test.sv
module fpcmp_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        gt, lt, eq, unordered, inf_any, a_zero, invalid, ready;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   fpcmp_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .op_a      (op_a),
      .op_b      (op_b),
      .gt        (gt),
      .lt        (lt),
      .eq        (eq),
      .unordered (unordered),
      .inf_any   (inf_any),
      .a_zero    (a_zero),
      .invalid   (invalid),
      .ready     (ready)
   );

   // Entry: tag, A, B, expected {gt,lt,eq,unordered,inf_any,a_zero,invalid}
   localparam int NV = 21;
   localparam logic [94:0] VEC [NV] = '{
      {"R4 ", 32'h3F800000, 32'h40000000, 7'b0100000},
      {"R3 ", 32'h40000000, 32'h3F800000, 7'b1000000},
      {"R5 ", 32'h3F800000, 32'h3F800000, 7'b0010000},
      {"R5 ", 32'h00000000, 32'h80000000, 7'b0010010},
      {"R9 ", 32'h80000000, 32'h00000000, 7'b0010010},
      {"R6 ", 32'hC0000000, 32'hBF800000, 7'b0100000},
      {"R6 ", 32'hBF800000, 32'hC0000000, 7'b1000000},
      {"R4 ", 32'hBF800000, 32'h3F800000, 7'b0100000},
      {"R7 ", 32'h7FC00000, 32'h3F800000, 7'b0001000},
      {"R10", 32'h7F800001, 32'h3F800000, 7'b0001001},
      {"R10", 32'h3F800000, 32'hFF800001, 7'b0001001},
      {"R8 ", 32'h7F800000, 32'h7F7FFFFF, 7'b1000100},
      {"R8 ", 32'hFF800000, 32'h7F800000, 7'b0100100},
      {"R8 ", 32'h7F800000, 32'h7F800000, 7'b0010100},
      {"R7 ", 32'h7FC00000, 32'h7F800000, 7'b0001100},
      {"R11", 32'h00000001, 32'h00000000, 7'b1000000},
      {"R11", 32'h80000001, 32'h00000000, 7'b0100000},
      {"R9 ", 32'h00000000, 32'h00000001, 7'b0100010},
      {"R11", 32'h007FFFFF, 32'h00800000, 7'b0100000},
      {"R7 ", 32'h00000000, 32'h7FC00000, 7'b0001010},
      {"R9 ", 32'h3F800000, 32'h00000000, 7'b1000000}
   };

   function automatic logic [6:0] flags_now();
      return {gt, lt, eq, unordered, inf_any, a_zero, invalid};
   endfunction

   task automatic check(input logic [23:0] req, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drive operands with a one-cycle load; return at the next falling edge
   task automatic apply(input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      op_a = a;
      op_b = b;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state, during and after reset
      repeat (2) @(negedge clk);
      check("R1", {24'd0, flags_now(), ready}, 32'd0, "flags in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", {24'd0, flags_now(), ready}, 32'd0, "flags after reset");

      // Table walk
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][70:39], VEC[i][38:7]);
         check(VEC[i][94:71], {25'd0, flags_now()}, {25'd0, VEC[i][6:0]},
               $sformatf("vector %0d flags", i));
         check("R2", {31'd0, ready}, 32'd1, $sformatf("vector %0d ready", i));
      end

      // R2: ready lasts one cycle, flags hold while operands move
      apply(32'h3F800000, 32'h40000000);
      @(negedge clk);
      op_a = 32'h40000000;
      op_b = 32'h3F800000;
      check("R2", {31'd0, ready}, 32'd0, "ready after one cycle");
      repeat (2) @(negedge clk);
      check("R2", {25'd0, flags_now()}, {25'd0, 7'b0100000}, "flags hold without load");

      // R2: back-to-back loads
      @(negedge clk);
      op_a = 32'hC0000000;
      op_b = 32'hBF800000;
      load = 1'b1;
      @(negedge clk);
      check("R2", {24'd0, flags_now(), ready}, {24'd0, 7'b0100000, 1'b1}, "first of pair");
      op_a = 32'h7F800000;
      op_b = 32'h7F800000;
      @(negedge clk);
      load = 1'b0;
      check("R2", {24'd0, flags_now(), ready}, {24'd0, 7'b0010100, 1'b1}, "second of pair");
      @(negedge clk);
      check("R2", {31'd0, ready}, 32'd0, "ready drops after pair");

      // R9: B zero, A negative nonzero; R10: quiet NaN does not raise invalid
      apply(32'hBF800000, 32'h80000000);
      check("R9", {25'd0, flags_now()}, {25'd0, 7'b0100000}, "B zero leaves a_zero low");
      apply(32'hFFC00001, 32'h7FC00000);
      check("R10", {25'd0, flags_now()}, {25'd0, 7'b0001000}, "quiet NaN pair");

      // R1: asynchronous reset clears held flags
      apply(32'h7F800001, 32'h00000000);
      #3 rst_n = 1'b0;
      #2;
      check("R1", {24'd0, flags_now(), ready}, 32'd0, "mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule